// File: doc/BRIEF.md
# Programmable Multi-Output Video Timing Generator

This block produces raster timing from a pixel clock. A horizontal counter steps through the pixels of each line, and a line counter steps through the lines of each field. Four sync output channels each produce their own horizontal and vertical sync waveform. Every edge of those waveforms is placed by software: a horizontal edge by a pixel number, and a vertical edge by a line number together with a pixel offset inside that line. The block also drives an active-video flag for a programmable rectangle, a field indicator, and an interrupt that reports the start of each field.

Configuration goes through a plain 32-bit register port. A write is taken on any clock edge where the write strobe is high. A read is combinational: `reg_rdata` always shows the register that `reg_addr` selects. The port has no back-pressure and no wait states. Timing, window and sync registers are held in two copies. Software writes a shadow copy. The counters and decoders use a working copy, which is loaded from the shadow only when a new frame begins or when a restart is requested, so a configuration written only in part never reaches the outputs.

The field length is given in half-lines, so the number of lines per field is that count halved. When the count is even, the video is progressive and every field is a top field. When it is odd, top and bottom fields alternate, and each field uses its own vertical sync and window settings.

Top module: `vid_timing_gen`

## Requirements
- R1: The pixel counter runs from 0 to L-1 and then returns to 0. L is the line length in bits 15:0 of register 0x00. When L is 0, the counter stays at 0.
- R2: Bits 15:0 of register 0x04 hold the field length H in half-lines. A field has H>>1 lines, numbered from 1. When H>>1 is 0, the line number stays at 1.
- R3: Writing a 1 to bit 0 of register 0x08 moves the counters, after one clock, to pixel 0 of line 1 of a top field, and loads the working copy. That register reads 1 only during the cycle after the write.
- R4: A write to a configuration register (0x00, 0x04, 0x10 to 0x1C, or a sync register) can be read back at once. It changes the outputs only after the next frame start (pixel 0 of line 1 of a top field, reached by counting) or after a restart.
- R5: For channel k, bits 15:0 of register 0x40+0x20k hold the hsync start pixel S, and bits 31:16 hold the stop pixel E. The hsync output is high for pixels S up to E-1. If S>E, the pulse wraps past the end of the line. If S=E, the output stays low.
- R6: Each channel has two vsync line registers, at +0x04 for the top field and +0x08 for the bottom field, and two vsync offset registers, at +0x0C for the top field and +0x10 for the bottom field. Bits 15:0 of the line and offset registers give the rising position, and bits 31:16 give the falling position. Positions are ordered by line first and then by pixel. The vsync output is high from the rising position up to, but not including, the falling position. It wraps around the end of the field when rise comes after fall, and stays low when the two positions are equal.
- R7: The active-video flag is high when the line number lies from the start line to the stop line, and the pixel number lies from the start pixel to the stop pixel, both ranges inclusive. Each start or stop register holds the line in bits 31:16 and the pixel in bits 15:0. The top field uses 0x10 for start and 0x14 for stop; the bottom field uses 0x18 and 0x1C.
- R8: Status register 0x20 has bit 1 for a top-field start and bit 0 for a bottom-field start. A bit is set by the clock edge that ends a cycle spent at pixel 0 of line 1 of the matching field.
- R9: Writing ones to register 0x24 clears the matching status bits. A field start on the same edge wins over the clear. Register 0x24 reads as 0.
- R10: Writing ones to 0x28 sets mask bits, and writing ones to 0x2C clears them. Both addresses read back the mask. The interrupt output is high exactly when some status bit and its mask bit are both 1.
- R11: When H is odd, the fields alternate top and bottom, and the field output is 1 during a bottom field. When H is even, the field output stays 0.
- R12: After reset the counters stand at pixel 0 of line 1 of a top field, status and mask are 0, all sync and window registers are 0, and L and H take their parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr |
| hsync_o | output | N_OUT | Horizontal sync, one bit per channel |
| vsync_o | output | N_OUT | Vertical sync, one bit per channel |
| active_o | output | 1 | Active-video window flag |
| field_o | output | 1 | 0 for a top field, 1 for a bottom field |
| irq_o | output | 1 | Field-start interrupt |

## Verification
The assertions check the following on every cycle:
- the pixel and line counters stay inside their programmed ranges;
- a restart lands on pixel 0 of line 1;
- an even field length never produces a bottom field;
- the working configuration changes only on a load;
- a field start sets its status bit;
- a status clear or a mask set takes effect on the next edge.

Some behaviours can only be shown by the bench scenarios, which run a cycle model beside the design. These are:
- the exact shape of each sync waveform, including pulses that wrap past the end of a line or field;
- the point in time at which a shadow write reaches the outputs;
- the alternation of fields for an odd half-line count;
- the interrupt level under random clears and mask changes.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int REG_AW = 10;

  localparam logic [REG_AW-1:0] A_LINE    = 10'h000;
  localparam logic [REG_AW-1:0] A_HALF    = 10'h004;
  localparam logic [REG_AW-1:0] A_RESTART = 10'h008;
  localparam logic [REG_AW-1:0] A_WTS     = 10'h010;
  localparam logic [REG_AW-1:0] A_WTE     = 10'h014;
  localparam logic [REG_AW-1:0] A_WBS     = 10'h018;
  localparam logic [REG_AW-1:0] A_WBE     = 10'h01C;
  localparam logic [REG_AW-1:0] A_STAT    = 10'h020;
  localparam logic [REG_AW-1:0] A_STCLR   = 10'h024;
  localparam logic [REG_AW-1:0] A_MSET    = 10'h028;
  localparam logic [REG_AW-1:0] A_MCLR    = 10'h02C;
  localparam int SYNC_BASE   = 'h40;
  localparam int SYNC_STRIDE = 'h20;

  typedef struct packed {
    logic [31:0] hs;
    logic [31:0] vl_top;
    logic [31:0] vl_bot;
    logic [31:0] vo_top;
    logic [31:0] vo_bot;
  } sync_cfg_t;

  typedef struct packed {
    logic [15:0] line_clks;
    logic [15:0] half_lines;
    logic [31:0] win_top_s;
    logic [31:0] win_top_e;
    logic [31:0] win_bot_s;
    logic [31:0] win_bot_e;
  } tim_cfg_t;

  // High from s up to but not including e; wraps when s > e; empty when equal.
  function automatic logic in_span(input logic [31:0] p, input logic [31:0] s,
                                   input logic [31:0] e);
    if (s == e)     return 1'b0;
    else if (s < e) return (p >= s) && (p < e);
    else            return (p >= s) || (p < e);
  endfunction
endpackage

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart_i,
  input  logic [15:0] line_clks,
  input  logic [15:0] half_lines,
  output logic [15:0] hcnt,
  output logic [15:0] lcnt,
  output logic        fld,
  output logic        load_o,
  output logic [1:0]  evt_o
);
  logic [15:0] lines;
  logic        h_end, l_end, nxt_fld, frame_wrap;

  assign lines      = {1'b0, half_lines[15:1]};
  assign h_end      = ({1'b0, hcnt} + 17'd1) >= {1'b0, line_clks};
  assign l_end      = lcnt >= lines;
  assign nxt_fld    = half_lines[0] ? ~fld : 1'b0;
  assign frame_wrap = h_end && l_end && !nxt_fld;
  assign load_o     = restart_i || frame_wrap;
  assign evt_o      = (hcnt == 16'd0 && lcnt == 16'd1) ? (fld ? 2'b01 : 2'b10) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      lcnt <= 16'd1;
      fld  <= 1'b0;
    end else if (restart_i) begin
      hcnt <= '0;
      lcnt <= 16'd1;
      fld  <= 1'b0;
    end else if (h_end) begin
      hcnt <= '0;
      if (l_end) begin
        lcnt <= 16'd1;
        fld  <= nxt_fld;
      end else begin
        lcnt <= lcnt + 16'd1;
      end
    end else begin
      hcnt <= hcnt + 16'd1;
    end
  end

  assert_hcnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_clks == 16'd0) ? (hcnt == 16'd0) : (hcnt < line_clks));

  assert_lcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt >= 16'd1) && ((lines == 16'd0) ? (lcnt == 16'd1) : (lcnt <= lines)));

  assert_restart_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (hcnt == 16'd0 && lcnt == 16'd1 && !fld));

  assert_even_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !half_lines[0] |-> !fld);
endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int N_OUT          = 4,
  parameter int DEF_LINE_CLKS  = 16,
  parameter int DEF_HALF_LINES = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [REG_AW-1:0]             addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  input  logic                          load_i,
  input  logic [1:0]                    evt_i,
  output logic                          restart_o,
  output logic                          irq_o,
  output tim_cfg_t                      tim_a_o,
  output sync_cfg_t [N_OUT-1:0]         sync_a_o
);
  tim_cfg_t              tim_s, tim_a;
  sync_cfg_t [N_OUT-1:0] sync_s;
  logic [1:0]            stat, mask, clr;
  logic                  rpend;

  localparam tim_cfg_t TIM_RST = '{line_clks: 16'(DEF_LINE_CLKS),
                                   half_lines: 16'(DEF_HALF_LINES),
                                   default: '0};

  assign clr = (wr_en && addr == A_STCLR) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_s <= TIM_RST;
      tim_a <= TIM_RST;
      stat  <= '0;
      mask  <= '0;
      rpend <= 1'b0;
    end else begin
      if (load_i) tim_a <= tim_s;
      stat  <= (stat & ~clr) | evt_i;
      rpend <= wr_en && addr == A_RESTART && wdata[0];
      if (wr_en) begin
        case (addr)
          A_LINE: tim_s.line_clks  <= wdata[15:0];
          A_HALF: tim_s.half_lines <= wdata[15:0];
          A_WTS:  tim_s.win_top_s  <= wdata;
          A_WTE:  tim_s.win_top_e  <= wdata;
          A_WBS:  tim_s.win_bot_s  <= wdata;
          A_WBE:  tim_s.win_bot_e  <= wdata;
          A_MSET: mask <= mask | wdata[1:0];
          A_MCLR: mask <= mask & ~wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_sync
    localparam logic [REG_AW-1:0] B = REG_AW'(SYNC_BASE + k * SYNC_STRIDE);
    sync_cfg_t s_q, a_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        a_q <= '0;
      end else begin
        if (load_i) a_q <= s_q;
        if (wr_en) begin
          case (addr)
            B:                s_q.hs     <= wdata;
            B + REG_AW'(4):   s_q.vl_top <= wdata;
            B + REG_AW'(8):   s_q.vl_bot <= wdata;
            B + REG_AW'(12):  s_q.vo_top <= wdata;
            B + REG_AW'(16):  s_q.vo_bot <= wdata;
            default: ;
          endcase
        end
      end
    end
    assign sync_s[k]   = s_q;
    assign sync_a_o[k] = a_q;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_LINE:         rdata = {16'b0, tim_s.line_clks};
      A_HALF:         rdata = {16'b0, tim_s.half_lines};
      A_RESTART:      rdata = {31'b0, rpend};
      A_WTS:          rdata = tim_s.win_top_s;
      A_WTE:          rdata = tim_s.win_top_e;
      A_WBS:          rdata = tim_s.win_bot_s;
      A_WBE:          rdata = tim_s.win_bot_e;
      A_STAT:         rdata = {30'b0, stat};
      A_MSET, A_MCLR: rdata = {30'b0, mask};
      default: ;
    endcase
    for (int k = 0; k < N_OUT; k++) begin
      if (addr == REG_AW'(SYNC_BASE + k * SYNC_STRIDE))      rdata = sync_s[k].hs;
      if (addr == REG_AW'(SYNC_BASE + k * SYNC_STRIDE + 4))  rdata = sync_s[k].vl_top;
      if (addr == REG_AW'(SYNC_BASE + k * SYNC_STRIDE + 8))  rdata = sync_s[k].vl_bot;
      if (addr == REG_AW'(SYNC_BASE + k * SYNC_STRIDE + 12)) rdata = sync_s[k].vo_top;
      if (addr == REG_AW'(SYNC_BASE + k * SYNC_STRIDE + 16)) rdata = sync_s[k].vo_bot;
    end
  end

  assign tim_a_o   = tim_a;
  assign restart_o = rpend;
  assign irq_o     = |(stat & mask);

  assert_hold_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(tim_a));

  assert_hold_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(sync_a_o));

  assert_top_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[1] |=> stat[1]);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STCLR && evt_i == 2'b00) |=> ((stat & $past(wdata[1:0])) == 2'b00));

  assert_mask_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MSET) |=> ((mask & $past(wdata[1:0])) == $past(wdata[1:0])));
endmodule

// File: rtl/vtg_sync_out.sv
module vtg_sync_out
  import vtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] hcnt,
  input  logic [15:0] lcnt,
  input  logic        fld,
  input  sync_cfg_t   cfg,
  output logic        hs_o,
  output logic        vs_o
);
  logic [31:0] vl, vo;

  assign vl   = fld ? cfg.vl_bot : cfg.vl_top;
  assign vo   = fld ? cfg.vo_bot : cfg.vo_top;
  assign hs_o = in_span({16'b0, hcnt}, {16'b0, cfg.hs[15:0]}, {16'b0, cfg.hs[31:16]});
  assign vs_o = in_span({lcnt, hcnt}, {vl[15:0], vo[15:0]}, {vl[31:16], vo[31:16]});

  assert_hs_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.hs[15:0] == cfg.hs[31:16]) |-> !hs_o);

  assert_vs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((vl[15:0] == vl[31:16]) && (vo[15:0] == vo[31:16])) |-> !vs_o);
endmodule

// File: rtl/vtg_window.sv
module vtg_window (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] hcnt,
  input  logic [15:0] lcnt,
  input  logic        fld,
  input  logic [31:0] top_s,
  input  logic [31:0] top_e,
  input  logic [31:0] bot_s,
  input  logic [31:0] bot_e,
  output logic        active_o
);
  logic [31:0] ws, we;

  assign ws       = fld ? bot_s : top_s;
  assign we       = fld ? bot_e : top_e;
  assign active_o = (lcnt >= ws[31:16]) && (lcnt <= we[31:16]) &&
                    (hcnt >= ws[15:0])  && (hcnt <= we[15:0]);

  assert_win_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (lcnt >= 16'd1));
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int N_OUT          = 4,
  parameter int DEF_LINE_CLKS  = 16,
  parameter int DEF_HALF_LINES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [9:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_OUT-1:0]  hsync_o,
  output logic [N_OUT-1:0]  vsync_o,
  output logic              active_o,
  output logic              field_o,
  output logic              irq_o
);
  tim_cfg_t              tim_a;
  sync_cfg_t [N_OUT-1:0] sync_a;
  logic [15:0]           hcnt, lcnt;
  logic                  fld, load, restart;
  logic [1:0]            evt;

  vtg_regs #(
    .N_OUT(N_OUT), .DEF_LINE_CLKS(DEF_LINE_CLKS), .DEF_HALF_LINES(DEF_HALF_LINES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .load_i(load), .evt_i(evt), .restart_o(restart),
    .irq_o(irq_o), .tim_a_o(tim_a), .sync_a_o(sync_a)
  );

  vtg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .line_clks(tim_a.line_clks), .half_lines(tim_a.half_lines),
    .hcnt(hcnt), .lcnt(lcnt), .fld(fld), .load_o(load), .evt_o(evt)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    vtg_sync_out u_sync (
      .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .lcnt(lcnt), .fld(fld),
      .cfg(sync_a[k]), .hs_o(hsync_o[k]), .vs_o(vsync_o[k])
    );
  end

  vtg_window u_win (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .lcnt(lcnt), .fld(fld),
    .top_s(tim_a.win_top_s), .top_e(tim_a.win_top_e),
    .bot_s(tim_a.win_bot_s), .bot_e(tim_a.win_bot_e),
    .active_o(active_o)
  );

  assign field_o = fld;
endmodule

// File: tb/vid_timing_gen_bench.sv
module vid_timing_gen_bench;
  localparam int N  = 4;
  localparam int DL = 16;
  localparam int DH = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] hs, vs;
  logic act, fld, irq;

  always #4 clk = ~clk;

  vid_timing_gen #(.N_OUT(N), .DEF_LINE_CLKS(DL), .DEF_HALF_LINES(DH)) u_vid_timing_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_en), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .hsync_o(hs), .vsync_o(vs), .active_o(act),
    .field_o(fld), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0, seen_bot = 0;
  int mh, ml, mf;
  logic [31:0] sh [0:255];
  logic [31:0] ac [0:255];
  logic [1:0] mst, mmask;
  bit mrp;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit span(longint p, longint s, longint e);
    if (s == e) return 0;
    if (s < e) return (p >= s) && (p < e);
    return (p >= s) || (p < e);
  endfunction

  function automatic bit is_cfg(logic [9:0] a);
    if (a[1:0] != 2'b00) return 0;
    if (a == 10'h000 || a == 10'h004) return 1;
    if (a >= 10'h010 && a <= 10'h01C) return 1;
    if (a >= 10'h040 && int'(a) < 'h40 + 'h20 * N && a[4:0] <= 5'h10) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [9:0] a);
    if (is_cfg(a)) return sh[a >> 2];
    if (a == 10'h020) return {30'b0, mst};
    if (a == 10'h028 || a == 10'h02C) return {30'b0, mmask};
    if (a == 10'h008) return {31'b0, mrp};
    return 32'b0;
  endfunction

  function automatic string tag_of(logic [9:0] a);
    if (a == 10'h020) return "R8 status readback";
    if (a == 10'h024) return "R9 clear reads zero";
    if (a == 10'h028 || a == 10'h02C) return "R10 mask readback";
    if (a == 10'h008) return "R3 restart readback";
    return "R4 shadow readback";
  endfunction

  function automatic bit e_hs(int k);
    logic [31:0] w = ac[16 + 8 * k];
    return span(mh, w[15:0], w[31:16]);
  endfunction

  function automatic bit e_vs(int k);
    logic [31:0] vl = ac[16 + 8 * k + (mf ? 2 : 1)];
    logic [31:0] vo = ac[16 + 8 * k + (mf ? 4 : 3)];
    longint p = longint'(ml) * 65536 + mh;
    return span(p, longint'(vl[15:0]) * 65536 + vo[15:0],
                   longint'(vl[31:16]) * 65536 + vo[31:16]);
  endfunction

  function automatic bit e_act();
    logic [31:0] s = ac[mf ? 6 : 4];
    logic [31:0] e = ac[mf ? 7 : 5];
    return ml >= s[31:16] && ml <= e[31:16] && mh >= s[15:0] && mh <= e[15:0];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) sh[i] = '0;
    sh[0] = DL; sh[1] = DH;
    ac = sh;
    mh = 0; ml = 1; mf = 0; mst = 0; mmask = 0; mrp = 0;
  endtask

  task automatic model_step(bit we, logic [9:0] a, logic [31:0] d);
    logic [1:0] ev, clr;
    int lines;
    bit ld = 0, nf;
    ev  = (mh == 0 && ml == 1) ? (mf ? 2'b01 : 2'b10) : 2'b00;
    clr = (we && a == 10'h024) ? d[1:0] : 2'b00;
    lines = int'(ac[1][15:0]) >> 1;
    if (mrp) begin
      mh = 0; ml = 1; mf = 0; ld = 1;
    end else if (mh + 1 >= int'(ac[0][15:0])) begin
      mh = 0;
      if (ml >= lines) begin
        nf = ac[1][0] ? !mf : 0;
        ml = 1; mf = nf;
        if (!nf) ld = 1;
      end else ml++;
    end else mh++;
    if (ld) ac = sh;
    mst = (mst & ~clr) | ev;
    if (we && a == 10'h028) mmask = mmask | d[1:0];
    if (we && a == 10'h02C) mmask = mmask & ~d[1:0];
    mrp = we && a == 10'h008 && d[0];
    if (we && is_cfg(a)) sh[a >> 2] = (a == 10'h000 || a == 10'h004) ? {16'b0, d[15:0]} : d;
  endtask

  task automatic cyc(bit we, logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    #1;
    if (!we) chk(tag_of(a), rdata, exp_rd(a));
    @(posedge clk);
    model_step(we, a, d);
    #2;
    for (int k = 0; k < N; k++) begin
      chk($sformatf("R5 R1 hsync ch%0d", k), 32'(hs[k]), 32'(e_hs(k)));
      chk($sformatf("R6 R2 vsync ch%0d", k), 32'(vs[k]), 32'(e_vs(k)));
    end
    chk("R7 active window", 32'(act), 32'(e_act()));
    chk("R11 field", 32'(fld), 32'(mf));
    chk("R10 irq", 32'(irq), 32'(|(mst & mmask)));
    if (fld) seen_bot++;
  endtask

  function automatic logic [31:0] rand_val(logic [9:0] a);
    if (a == 10'h000) return 1 + $urandom % 20;
    if (a == 10'h004) return $urandom % 25;
    if (a >= 10'h010 && a <= 10'h01C) return {16'($urandom % 12), 16'($urandom % 20)};
    case (a[4:0])
      5'h00: return {16'($urandom % 22), 16'($urandom % 22)};
      5'h04, 5'h08: return {16'($urandom % 12), 16'($urandom % 12)};
      default: return {16'($urandom % 24), 16'($urandom % 24)};
    endcase
  endfunction

  function automatic logic [9:0] rand_cfg_addr();
    if ($urandom % 3 == 0) begin
      case ($urandom % 6)
        0: return 10'h000;
        1: return 10'h004;
        2: return 10'h010;
        3: return 10'h014;
        4: return 10'h018;
        default: return 10'h01C;
      endcase
    end
    return 10'(32'h40 + 32'h20 * ($urandom % N) + 4 * ($urandom % 5));
  endfunction

  function automatic logic [9:0] rand_rd_addr();
    case ($urandom % 8)
      0: return 10'h020;
      1: return 10'h028;
      2: return 10'h02C;
      3: return 10'h008;
      4: return 10'h024;
      default: return rand_cfg_addr();
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [9:0] a;
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    // R12: state held in reset
    #1;
    addr = 10'h020; #1 chk("R12 status at reset", rdata, 32'h0);
    addr = 10'h028; #1 chk("R12 mask at reset", rdata, 32'h0);
    addr = 10'h000; #1 chk("R12 line default", rdata, DL);
    addr = 10'h004; #1 chk("R12 half default", rdata, DH);
    addr = 10'h040; #1 chk("R12 sync zero", rdata, 32'h0);
    chk("R12 outputs low", {hs, vs, act, fld, irq}, '0);
    @(negedge clk); rst_n = 1'b1;

    // Directed setup: 14 clocks/line, 8 lines, progressive
    cyc(1, 10'h000, 14);
    cyc(1, 10'h004, 16);
    cyc(1, 10'h010, {16'd2, 16'd3});
    cyc(1, 10'h014, {16'd6, 16'd10});
    cyc(1, 10'h040, {16'd1, 16'd0});      // R5 plain pulse
    cyc(1, 10'h060, {16'd2, 16'd11});     // R5 wrapping pulse
    cyc(1, 10'h080, {16'd5, 16'd5});      // R5 empty
    cyc(1, 10'h044, {16'd2, 16'd8});      // R6 rise line 8, fall line 2 (wrap)
    cyc(1, 10'h04C, {16'd3, 16'd20});     // offset beyond line end
    cyc(1, 10'h064, {16'd3, 16'd1});
    cyc(1, 10'h06C, {16'd7, 16'd4});
    cyc(1, 10'h028, 32'h3);
    // R4: readback immediate, outputs still follow old copy until restart
    cyc(0, 10'h000, 0);
    cyc(1, 10'h008, 1);
    cyc(0, 10'h008, 0);
    cyc(0, 10'h008, 0);
    chk("R3 restart self-clear", rdata, 32'h0);
    repeat (300) cyc(0, 10'h020, 0);
    cyc(1, 10'h024, 32'h3);
    cyc(0, 10'h020, 0);

    // R11: odd half-line count
    cyc(1, 10'h004, 15);
    cyc(1, 10'h018, {16'd1, 16'd0});
    cyc(1, 10'h01C, {16'd4, 16'd6});
    cyc(1, 10'h048, {16'd2, 16'd1});
    cyc(1, 10'h008, 1);
    repeat (400) cyc(0, 10'h020, 0);
    chk("R11 bottom field seen", 32'(seen_bot > 0), 32'd1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 1000;
      if (r < 120) begin
        a = rand_cfg_addr();
        cyc(1, a, rand_val(a));
      end else if (r < 150) cyc(1, 10'h024, $urandom % 4);
      else if (r < 165) cyc(1, 10'h028, $urandom % 4);
      else if (r < 180) cyc(1, 10'h02C, $urandom % 4);
      else if (r < 185) cyc(1, 10'h008, 1);
      else cyc(0, rand_rd_addr(), 0);
    end
    // Corner: zero line length and zero field length
    cyc(1, 10'h000, 0);
    cyc(1, 10'h004, 0);
    cyc(1, 10'h008, 1);
    repeat (20) cyc(0, 10'h020, 0);
    cyc(1, 10'h000, 9);
    cyc(1, 10'h004, 9);
    cyc(1, 10'h008, 1);
    repeat (200) cyc(0, rand_rd_addr(), 0);

    summary();
    $finish;
  end
endmodule